// File: doc/BRIEF.md
# Audio Master-Mode Clock Generator

This block runs entirely on the converter's master clock and generates the two timing outputs an audio serial port needs in clock-master mode: a frame clock (`lrck`) whose rate is the sample rate, and a bit clock (`sclk`) that runs at exactly 64 periods per frame. The number of master-clock cycles in one frame is a prescale factor (×1, ×1.5, ×2, ×3 or ×4) times a divider set by the speed mode: 256 for single speed, 128 for double speed and 64 for quad speed.

Every output comes from a flop fed by a small set of counters, so only the rising edge of the master clock is used. Settings are sampled only at frame boundaries, so a frame that has started always completes. An illegal setting stops both clocks low and raises an error flag. A valid setting restarts the clocks at the next cycle. A one-cycle `frameStart` strobe marks the cycle in which `lrck` begins each frame low.

Top module: `audio_master_clkgen`

## Requirements
- R1: While `rst` is high and in the first cycle after it is released, `lrck`, `sclk`, `frameStart` and `cfgError` are all 0.
- R2: The bit-clock period T, in master-clock cycles, is P×D/64. `prescaleSel` codes 0,1,2,3,4 select P = 1, 1.5, 2, 3, 4. `speedMode` 00/01/10 selects D = 256/128/64.
- R3: Within each bit-clock period, `sclk` is low for floor(T/2) cycles and then high for the remaining ceil(T/2) cycles. Each frame begins with `sclk` low.
- R4: A frame holds exactly 64 bit-clock periods (64×T cycles). `lrck` is low for the first 32 periods and high for the last 32.
- R5: `lrck` changes level only in the cycle where `sclk` falls.
- R6: `frameStart` is high for exactly the first cycle of each frame, the cycle in which `lrck` goes (or starts) low.
- R7: `speedMode` = 11 is illegal. At the next frame boundary `lrck` and `sclk` are held low, no `frameStart` is issued, and `cfgError` is 1.
- R8: `prescaleSel` codes 5–7 are illegal. So is any setting whose bit-clock period is below 2 cycles (quad speed with ×1 or ×1.5). Each of these is handled as in R7.
- R9: A change of `speedMode` or `prescaleSel` during a frame has no effect until that frame's last cycle has passed.
- R10: While the block is stopped, applying a legal setting clears `cfgError` and starts a new frame at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all logic on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| speedMode | input | 2 | 00 single, 01 double, 10 quad, 11 illegal |
| prescaleSel | input | 3 | Prescale code 0..4 = ×1, ×1.5, ×2, ×3, ×4; 5..7 illegal |
| lrck | output | 1 | Frame clock, one period per sample |
| sclk | output | 1 | Bit clock, 64 periods per frame |
| frameStart | output | 1 | One-cycle strobe on the first cycle of each frame |
| cfgError | output | 1 | Set while the latched setting is illegal |

## Verification
The corner cases are the odd bit-clock periods of 3 cycles (double ×1.5 and quad ×3). A design that rounded the two halves the same way would put 63 or 65 bit clocks in a frame and drift `lrck` away from an `sclk` falling edge. Quad speed with ×1 and ×1.5 sits on the period-2 rejection limit, and a wrong bound would either accept a sub-2-cycle clock or reject quad ×2. Setting changes made mid-frame, including a change to an illegal mode, must leave the current frame unchanged up to its boundary. A block that reacted at once would cut the frame short. Recovery from the error state must restart with `frameStart`, `lrck` low and `sclk` low in the very next cycle.

// File: rtl/audclk_pkg.sv
package audclk_pkg;
  // Longest bit-clock period in master-clock cycles (single speed, x4).
  localparam int MAX_PERIOD = 16;
  localparam int PERIOD_W   = $clog2(MAX_PERIOD + 1);

  // Strobes from control to datapath, valid on a frame boundary.
  typedef struct packed {
    logic load;  // start a new frame with the decoded period
    logic halt;  // stop, outputs low
  } clkStrobe_t;
endpackage

// File: rtl/audclk_ctrl.sv
module audclk_ctrl
  import audclk_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          speedMode,
  input  logic [2:0]          prescaleSel,
  input  logic                frameEnd,
  output clkStrobe_t          strobe,
  output logic [PERIOD_W-1:0] period,
  output logic                cfgError
);
  localparam int CALC_W = PERIOD_W + 2;

  logic [3:0]        halfUnits;  // prescale factor times two
  logic [CALC_W-1:0] scaled;
  logic [CALC_W-1:0] periodCalc;
  logic              cfgOk;

  always_comb begin
    case (prescaleSel)
      3'd0:    halfUnits = 4'd2;
      3'd1:    halfUnits = 4'd3;
      3'd2:    halfUnits = 4'd4;
      3'd3:    halfUnits = 4'd6;
      3'd4:    halfUnits = 4'd8;
      default: halfUnits = 4'd0;
    endcase
    // period = halfUnits * D / 128, D = 256 >> mode
    scaled     = CALC_W'(halfUnits) << 2;
    periodCalc = scaled >> (speedMode + 2'd1);
    cfgOk      = (speedMode != 2'b11) && (halfUnits != 4'd0) &&
                 (periodCalc >= CALC_W'(2));
  end

  assign period      = periodCalc[PERIOD_W-1:0];
  assign strobe.load = frameEnd && cfgOk;
  assign strobe.halt = frameEnd && !cfgOk;

  always_ff @(posedge clk) begin
    if (rst)           cfgError <= 1'b0;
    else if (frameEnd) cfgError <= !cfgOk;
  end

  // R9: error state changes only across a boundary
  p_err_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !frameEnd |=> $stable(cfgError));
endmodule

// File: rtl/audclk_datapath.sv
module audclk_datapath
  import audclk_pkg::*;
#(
  parameter int FRAME_BITS = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  clkStrobe_t          strobe,
  input  logic [PERIOD_W-1:0] newPeriod,
  output logic                frameEnd,
  output logic                lrck,
  output logic                sclk,
  output logic                frameStart
);
  localparam int BIT_W     = $clog2(FRAME_BITS);
  localparam int HALF_BITS = FRAME_BITS / 2;

  logic                running, runN;
  logic [PERIOD_W-1:0] periodQ, periodN;
  logic [PERIOD_W-1:0] phaseCnt, phaseN;
  logic [BIT_W-1:0]    bitCnt, bitN;
  logic                lastPhase;

  assign lastPhase = (phaseCnt == periodQ - PERIOD_W'(1));
  assign frameEnd  = !running ||
                     (lastPhase && bitCnt == BIT_W'(FRAME_BITS - 1));

  always_comb begin
    runN    = running;
    periodN = periodQ;
    phaseN  = phaseCnt;
    bitN    = bitCnt;
    if (strobe.load) begin
      runN    = 1'b1;
      periodN = newPeriod;
      phaseN  = '0;
      bitN    = '0;
    end else if (strobe.halt) begin
      runN   = 1'b0;
      phaseN = '0;
      bitN   = '0;
    end else if (running) begin
      if (lastPhase) begin
        phaseN = '0;
        bitN   = bitCnt + BIT_W'(1);
      end else begin
        phaseN = phaseCnt + PERIOD_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running    <= 1'b0;
      periodQ    <= PERIOD_W'(2);
      phaseCnt   <= '0;
      bitCnt     <= '0;
      sclk       <= 1'b0;
      lrck       <= 1'b0;
      frameStart <= 1'b0;
    end else begin
      running    <= runN;
      periodQ    <= periodN;
      phaseCnt   <= phaseN;
      bitCnt     <= bitN;
      sclk       <= runN && (phaseN >= (periodN >> 1));
      lrck       <= runN && (bitN >= BIT_W'(HALF_BITS));
      frameStart <= strobe.load;
    end
  end

  // R2: phase counter stays inside the latched period
  p_phase_range_r2: assert property (@(posedge clk) disable iff (rst)
    running |-> phaseCnt < periodQ);
  // R5: frame clock moves only with a bit-clock falling edge
  p_lrck_on_fall_r5: assert property (@(posedge clk) disable iff (rst)
    ($rose(lrck) || $fell(lrck)) |-> $fell(sclk));
  // R6: a running frame clock falls only at a frame start
  p_fall_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    ($fell(lrck) && running) |-> frameStart);
  // R6: frame start sees both clocks low
  p_start_low_r6: assert property (@(posedge clk) disable iff (rst)
    frameStart |-> (!lrck && !sclk));
  // R9: period held for the whole frame
  p_period_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (running && !frameEnd) |=> $stable(periodQ));
endmodule

// File: rtl/audio_master_clkgen.sv
module audio_master_clkgen
  import audclk_pkg::*;
#(
  parameter int FRAME_BITS = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] speedMode,
  input  logic [2:0] prescaleSel,
  output logic       lrck,
  output logic       sclk,
  output logic       frameStart,
  output logic       cfgError
);
  clkStrobe_t          strobe;
  logic [PERIOD_W-1:0] period;
  logic                frameEnd;

  audclk_ctrl u_ctrl (
    .clk(clk), .rst(rst), .speedMode(speedMode), .prescaleSel(prescaleSel),
    .frameEnd(frameEnd), .strobe(strobe), .period(period), .cfgError(cfgError)
  );

  audclk_datapath #(.FRAME_BITS(FRAME_BITS)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .newPeriod(period),
    .frameEnd(frameEnd), .lrck(lrck), .sclk(sclk), .frameStart(frameStart)
  );

  // R7/R8: an illegal setting keeps every output quiet
  p_error_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    cfgError |-> (!lrck && !sclk && !frameStart));
endmodule

// File: tb/audio_master_clkgen_tb.sv
module audio_master_clkgen_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] speedMode = 2'd0;
  logic [2:0] prescaleSel = 3'd0;
  logic       lrck, sclk, frameStart, cfgError;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  audio_master_clkgen u_dut (
    .clk(clk), .rst(rst), .speedMode(speedMode), .prescaleSel(prescaleSel),
    .lrck(lrck), .sclk(sclk), .frameStart(frameStart), .cfgError(cfgError)
  );

  // {mode[9:8], sel[7:5], expected period[4:0]}; period 0 = illegal
  localparam logic [9:0] VECS [0:16] = '{
    {2'd0, 3'd0, 5'd4},  {2'd0, 3'd1, 5'd6},  {2'd0, 3'd2, 5'd8},
    {2'd0, 3'd3, 5'd12}, {2'd0, 3'd4, 5'd16},
    {2'd1, 3'd0, 5'd2},  {2'd1, 3'd1, 5'd3},  {2'd1, 3'd2, 5'd4},
    {2'd1, 3'd3, 5'd6},  {2'd1, 3'd4, 5'd8},
    {2'd2, 3'd0, 5'd0},  {2'd2, 3'd1, 5'd0},  {2'd2, 3'd2, 5'd2},
    {2'd2, 3'd3, 5'd3},  {2'd2, 3'd4, 5'd4},
    {2'd3, 3'd0, 5'd0},  {2'd0, 3'd5, 5'd0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic doReset(input logic [1:0] m, input logic [2:0] s);
    @(negedge clk);
    rst = 1'b1;
    speedMode = m;
    prescaleSel = s;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // Compares one full frame cycle by cycle (R3, R4, R6). Entered at the
  // negedge of the frame's first cycle (or waits for it); leaves at the
  // negedge of the following frame's first cycle. At cycle chgAt the inputs
  // are switched to newM/newS (R9).
  task automatic runFrame(input int per, input string req, input bit waitStart,
                          input int chgAt, input logic [1:0] newM,
                          input logic [2:0] newS);
    int bad = 0;
    int actV = 0;
    int expV = 0;
    if (waitStart) begin
      for (int w = 0; w < 50 && !frameStart; w++) @(negedge clk);
    end
    for (int k = 0; k < 64 * per; k++) begin
      logic expS, expL, expF;
      expS = (k % per) >= (per / 2);
      expL = (k / per) >= 32;
      expF = (k == 0);
      if ({sclk, lrck, frameStart} !== {expS, expL, expF}) begin
        if (bad == 0) begin
          actV = {29'd0, sclk, lrck, frameStart};
          expV = {29'd0, expS, expL, expF};
        end
        bad++;
      end
      if (k == chgAt) begin
        speedMode = newM;
        prescaleSel = newS;
      end
      @(negedge clk);
    end
    check(bad == 0, req, actV, expV);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check({lrck, sclk, frameStart, cfgError} === 4'b0000, "R1 reset outputs",
          {lrck, sclk, frameStart, cfgError}, 0);

    // Table walk: R2/R3/R4/R6 for legal settings, R7/R8 for illegal ones
    for (int i = 0; i < 17; i++) begin
      logic [1:0] m;
      logic [2:0] s;
      int per;
      m = VECS[i][9:8];
      s = VECS[i][7:5];
      per = int'(VECS[i][4:0]);
      doReset(m, s);
      if (per == 0) begin
        int act = 0;
        repeat (3) @(negedge clk);
        check(cfgError === 1'b1, (m == 2'd3) ? "R7 error flag" : "R8 error flag",
              cfgError, 1);
        for (int k = 0; k < 100; k++) begin
          if (lrck || sclk || frameStart) act++;
          @(negedge clk);
        end
        check(act == 0, (m == 2'd3) ? "R7 outputs low" : "R8 outputs low", act, 0);
      end else begin
        @(negedge clk);
        check(frameStart === 1'b1 && cfgError === 1'b0, "R1 first frame start",
              {frameStart, cfgError}, 2);
        runFrame(per, "R2 R3 R4 frame shape", 0, -1, m, s);
        check(frameStart === 1'b1, "R6 next frame start", frameStart, 1);
      end
    end

    // R9: change period mid-frame, old frame completes, new one follows
    doReset(2'd0, 3'd0);
    runFrame(4, "R9 old frame intact", 1, 10, 2'd1, 3'd0);
    runFrame(2, "R9 new setting at boundary", 0, -1, 2'd1, 3'd0);

    // R9/R7: illegal mode applied mid-frame waits for the boundary
    runFrame(2, "R9 frame before illegal mode", 0, 5, 2'd3, 3'd0);
    check({cfgError, lrck, sclk, frameStart} === 4'b1000, "R7 stop at boundary",
          {cfgError, lrck, sclk, frameStart}, 8);

    // R10: recovery with a legal setting
    repeat (5) @(negedge clk);
    speedMode = 2'd0;
    prescaleSel = 3'd2;
    @(negedge clk);
    check(frameStart === 1'b1 && cfgError === 1'b0 && !lrck && !sclk,
          "R10 restart", {frameStart, cfgError, lrck, sclk}, 8);
    runFrame(8, "R10 frame after restart", 0, -1, 2'd0, 3'd2);

    // R5: lrck edges fall on sclk falling edges (odd period 3)
    doReset(2'd2, 3'd3);
    begin
      int bad = 0;
      logic pL, pS;
      @(negedge clk);
      pL = lrck;
      pS = sclk;
      for (int k = 0; k < 3 * 64 * 2; k++) begin
        @(negedge clk);
        if (lrck !== pL && !(pS === 1'b1 && sclk === 1'b0)) bad++;
        pL = lrck;
        pS = sclk;
      end
      check(bad == 0, "R5 lrck on sclk fall", bad, 0);
    end

    finishRun();
  end
endmodule